// File: doc/BRIEF.md
# BCD Calendar Clock with Masked Alarm

This block keeps wall-clock time and a calendar in packed BCD registers: seconds, minutes, hours, day of week, date, month and a two-digit year. It advances by one second on each cycle in which a one-cycle, one-hertz enable pulse arrives. That pulse is derived elsewhere from a slow clock. Hours run in either 24-hour or 12-hour form, selected per value written. February takes its length from a divisible-by-four test on the year.

Four alarm registers hold seconds, minutes, hours and day of week, each with a mask bit. Masks let the alarm repeat weekly, daily, hourly, every minute or every second. A match sets an interrupt flag, and the interrupt output follows that flag when the enable bit allows it. A parallel register port with chip select, write enable, address and data lets a host load and read every field. A control register stops time, write-protects the registers and enables the interrupt.

Top module: `bcd_alarm_clock`

Register map (address: content): 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 alarm seconds, 8 alarm minutes, 9 alarm hours, 10 alarm day, 11 control, 12 status, 13 to 15 reserved.

## Requirements
- R1: After reset the time reads 00:00:00 in 24-hour form, day of week 01, date 01, month 01, year 00. Alarm registers, control and status read 00.
- R2: Seconds and minutes count in BCD (x9 goes to (x+1)0), and 59 wraps to 00 with a carry into the next field.
- R3: Hours bit 6 = 0 selects 24-hour form: the hour counts 00 to 23, and after 23:59:59 comes 00:00:00 with the day advanced.
- R4: Hours bit 6 = 1 selects 12-hour form, where bit 5 = 1 means PM and bits 4:0 hold 01 to 12. 11 goes to 12 with the PM bit toggled, and 12 goes to 01 with it kept. Only 11:59:59 PM to 12:00:00 AM advances the day.
- R5: The date wraps to 01 after day 31 (01,03,05,07,08,10,12), day 30 (04,06,09,11), or in month 02 after day 29 when the BCD year is divisible by four (00 included) and day 28 otherwise. A date wrap advances the month, and month 12 wraps to 01 while incrementing the year (99 wraps to 00).
- R6: Day of week counts 1 to 7 and wraps 7 to 1 whenever the day advances.
- R7: On a second step, the flag in status bit 0 is set when every alarm lane either has its mask bit 7 set or equals the new time field (alarm day compares with day of week). All masks clear gives weekly, day masked gives daily, day+hour masked hourly, day+hour+minute masked every minute, and all masked every second.
- R8: Any read or write of addresses 7 to 10 clears the flag, unless a match sets it in the same cycle.
- R9: Output irq is high exactly while the flag and control bit 0 (interrupt enable) are both 1.
- R10: While control bit 7 is 1 the time does not advance.
- R11: While control bit 6 is 1, writes to every address other than control are ignored. The control register stays writable so protection can be lifted.
- R12: Unused bits read 0 (seconds/minutes/hours bit 7, day of week bits 7:3, date bits 7:6, month bits 7:5, alarm day bits 6:3, control bits 5:1, status bits 7:1), and reserved addresses 13 to 15 read 0.
- R13: A write to a time register in the same cycle as the one-hertz pulse takes the written value, and that pulse is lost for all fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| reg_cs | input | 1 | Register access select |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the addressed register |
| irq | output | 1 | Alarm interrupt, active high |

## Verification
The assertions assume that the host writes only legal BCD values within each field's range. They also assume that tick_1hz is high for a single cycle at a time. Under those conditions the seconds and day-of-week ranges they check can only be broken by a counting fault. The bench writes only well-formed BCD times and dates, apart from bits that the write masks are meant to drop. It pulses the second enable for exactly one cycle, and it holds every register access for exactly one clock edge.

// File: rtl/cal_pkg.sv
package cal_pkg;
   localparam int unsigned FIELD_W = 7;
   localparam int unsigned N_ALARM = 4;

   localparam logic [3:0] A_SEC   = 4'd0;
   localparam logic [3:0] A_MIN   = 4'd1;
   localparam logic [3:0] A_HOUR  = 4'd2;
   localparam logic [3:0] A_DOW   = 4'd3;
   localparam logic [3:0] A_DATE  = 4'd4;
   localparam logic [3:0] A_MON   = 4'd5;
   localparam logic [3:0] A_YEAR  = 4'd6;
   localparam logic [3:0] A_ASEC  = 4'd7;
   localparam logic [3:0] A_ADAY  = 4'd10;
   localparam logic [3:0] A_CTRL  = 4'd11;
   localparam logic [3:0] A_STAT  = 4'd12;

   localparam int unsigned CTL_STOP = 7;
   localparam int unsigned CTL_WP   = 6;
   localparam int unsigned CTL_AIE  = 0;

   typedef struct packed {
      logic [6:0] sec;
      logic [6:0] min;
      logic [6:0] hour;
      logic [2:0] dow;
      logic [5:0] date;
      logic [4:0] mon;
      logic [7:0] year;
   } cal_time_t;

   function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
      if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic [7:0] wmask(input logic [3:0] a);
      case (a)
         A_SEC, A_MIN, A_HOUR: return 8'h7F;
         A_DOW:                return 8'h07;
         A_DATE:               return 8'h3F;
         A_MON:                return 8'h1F;
         A_YEAR:               return 8'hFF;
         A_ADAY:               return 8'h87;
         A_CTRL:               return 8'hC1;
         default: begin
            if (a >= A_ASEC && a < A_ADAY) return 8'hFF;
            return 8'h00;
         end
      endcase
   endfunction

   function automatic logic year_leap(input logic [7:0] y);
      logic [4:0] s;
      s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
      return (s[1:0] == 2'b00);
   endfunction

   function automatic logic [5:0] month_last(input logic [4:0] m, input logic [7:0] y);
      case (m)
         5'h02:                      return year_leap(y) ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         default:                    return 6'h31;
      endcase
   endfunction
endpackage

// File: rtl/cal_time_core.sv
module cal_time_core
   import cal_pkg::*;
#(
   parameter logic [7:0] RESET_YEAR = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       adv,
   input  logic       wr_en,
   input  logic [3:0] wr_addr,
   input  logic [7:0] wr_data,
   output cal_time_t  cur,
   output cal_time_t  nxt
);
   logic       s_wrap, m_wrap, h_wrap, day_c, d_wrap, mo_wrap;
   logic [7:0] s_i, m_i, h_i, d_i, mo_i, y_i;
   logic       pm;

   always_comb begin
      nxt    = cur;
      s_i    = bcd_inc8({1'b0, cur.sec});
      m_i    = bcd_inc8({1'b0, cur.min});
      d_i    = bcd_inc8({2'b00, cur.date});
      mo_i   = bcd_inc8({3'b000, cur.mon});
      y_i    = bcd_inc8(cur.year);
      pm     = cur.hour[5];
      h_i    = '0;
      s_wrap = (cur.sec == 7'h59);
      m_wrap = s_wrap && (cur.min == 7'h59);
      h_wrap = 1'b0;
      day_c  = 1'b0;

      nxt.sec = s_wrap ? 7'h00 : s_i[6:0];
      if (s_wrap) nxt.min = (cur.min == 7'h59) ? 7'h00 : m_i[6:0];

      if (m_wrap) begin
         if (cur.hour[6]) begin
            h_i = bcd_inc8({3'b000, cur.hour[4:0]});
            if (cur.hour[4:0] == 5'h11) begin
               nxt.hour = {1'b1, ~pm, 5'h12};
               day_c    = pm;
            end else if (cur.hour[4:0] == 5'h12) begin
               nxt.hour = {1'b1, pm, 5'h01};
            end else begin
               nxt.hour = {1'b1, pm, h_i[4:0]};
            end
         end else begin
            h_i    = bcd_inc8({2'b00, cur.hour[5:0]});
            h_wrap = (cur.hour[5:0] == 6'h23);
            nxt.hour = h_wrap ? 7'h00 : {1'b0, h_i[5:0]};
            day_c    = h_wrap;
         end
      end

      d_wrap  = day_c && (cur.date == month_last(cur.mon, cur.year));
      mo_wrap = d_wrap && (cur.mon == 5'h12);
      if (day_c) begin
         nxt.dow  = (cur.dow == 3'd7) ? 3'd1 : cur.dow + 3'd1;
         nxt.date = d_wrap ? 6'h01 : d_i[5:0];
      end
      if (d_wrap)  nxt.mon  = mo_wrap ? 5'h01 : mo_i[4:0];
      if (mo_wrap) nxt.year = (cur.year == 8'h99) ? 8'h00 : y_i;
   end

   logic [7:0] wd;
   assign wd = wr_data & wmask(wr_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur <= '{sec: 7'h00, min: 7'h00, hour: 7'h00, dow: 3'd1,
                  date: 6'h01, mon: 5'h01, year: RESET_YEAR};
      end else if (wr_en) begin
         case (wr_addr)
            A_SEC:   cur.sec  <= wd[6:0];
            A_MIN:   cur.min  <= wd[6:0];
            A_HOUR:  cur.hour <= wd[6:0];
            A_DOW:   cur.dow  <= wd[2:0];
            A_DATE:  cur.date <= wd[5:0];
            A_MON:   cur.mon  <= wd[4:0];
            A_YEAR:  cur.year <= wd;
            default: ;
         endcase
      end else if (adv) begin
         cur <= nxt;
      end
   end
endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit #(
   parameter  int unsigned N_LANE = 4,
   parameter  int unsigned FLD_W  = 7,
   localparam int unsigned IDX_W  = $clog2(N_LANE),
   localparam int unsigned REG_W  = FLD_W + 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [REG_W-1:0]              wr_data,
   input  logic                          access,
   input  logic                          chk,
   input  logic [N_LANE-1:0][FLD_W-1:0]  lane_time,
   output logic [N_LANE-1:0][REG_W-1:0]  alm_q,
   output logic                          irqf
);
   logic [N_LANE-1:0] lane_ok;

   for (genvar i = 0; i < N_LANE; i++) begin : g_lane
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                q <= '0;
         else if (wr_en && wr_idx == IDX_W'(i))     q <= wr_data;
      end
      assign alm_q[i]   = q;
      assign lane_ok[i] = q[REG_W-1] | (q[FLD_W-1:0] == lane_time[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 irqf <= 1'b0;
      else if (chk && &lane_ok)   irqf <= 1'b1;
      else if (access)            irqf <= 1'b0;
   end
endmodule

// File: rtl/bcd_alarm_clock.sv
module bcd_alarm_clock
   import cal_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 8,
   parameter bit          RDATA_REG  = 1'b0,
   parameter logic [7:0]  RESET_YEAR = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              reg_cs,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   localparam int unsigned IDX_W = $clog2(N_ALARM);

   if (DATA_W != 8) begin : g_bad_data
      $error("bcd_alarm_clock: DATA_W must be 8");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("bcd_alarm_clock: ADDR_W must be at least 4");
   end

   logic [3:0] a4;
   logic       in_map;
   if (ADDR_W > 4) begin : g_hi_addr
      assign in_map = (reg_addr[ADDR_W-1:4] == '0);
   end else begin : g_no_hi
      assign in_map = 1'b1;
   end
   assign a4 = reg_addr[3:0];

   logic [7:0] ctl_q;
   logic       wr_ok, time_wr, alm_acc, alm_wr, tick_adv, irqf;
   logic [7:0] wd;
   cal_time_t  t_cur, t_nxt;
   logic [N_ALARM-1:0][FIELD_W-1:0] lane_time;
   logic [N_ALARM-1:0][7:0]         alm_q;

   assign wd       = reg_wdata[7:0] & wmask(a4);
   assign wr_ok    = reg_cs && reg_we && in_map && !ctl_q[CTL_WP];
   assign time_wr  = wr_ok && (a4 <= A_YEAR);
   assign alm_acc  = reg_cs && in_map && (a4 >= A_ASEC) && (a4 <= A_ADAY);
   assign alm_wr   = wr_ok && alm_acc;
   assign tick_adv = tick_1hz && !ctl_q[CTL_STOP] && !time_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        ctl_q <= '0;
      else if (reg_cs && reg_we && in_map && a4 == A_CTRL) ctl_q <= wd;
   end

   cal_time_core #(.RESET_YEAR(RESET_YEAR)) u_time (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (tick_adv),
      .wr_en   (time_wr),
      .wr_addr (a4),
      .wr_data (reg_wdata[7:0]),
      .cur     (t_cur),
      .nxt     (t_nxt)
   );

   assign lane_time[0] = t_nxt.sec;
   assign lane_time[1] = t_nxt.min;
   assign lane_time[2] = t_nxt.hour;
   assign lane_time[3] = {4'b0000, t_nxt.dow};

   cal_alarm_unit #(.N_LANE(N_ALARM), .FLD_W(FIELD_W)) u_alarm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (alm_wr),
      .wr_idx    (IDX_W'(a4 - A_ASEC)),
      .wr_data   (wd),
      .access    (alm_acc),
      .chk       (tick_adv),
      .lane_time (lane_time),
      .alm_q     (alm_q),
      .irqf      (irqf)
   );

   assign irq = irqf && ctl_q[CTL_AIE];

   logic [7:0] rd_comb;
   always_comb begin
      rd_comb = '0;
      if (in_map) begin
         case (a4)
            A_SEC:   rd_comb = {1'b0, t_cur.sec};
            A_MIN:   rd_comb = {1'b0, t_cur.min};
            A_HOUR:  rd_comb = {1'b0, t_cur.hour};
            A_DOW:   rd_comb = {5'b0, t_cur.dow};
            A_DATE:  rd_comb = {2'b0, t_cur.date};
            A_MON:   rd_comb = {3'b0, t_cur.mon};
            A_YEAR:  rd_comb = t_cur.year;
            A_CTRL:  rd_comb = ctl_q;
            A_STAT:  rd_comb = {7'b0, irqf};
            default: if (a4 >= A_ASEC && a4 <= A_ADAY) rd_comb = alm_q[IDX_W'(a4 - A_ASEC)];
         endcase
      end
   end

   if (RDATA_REG) begin : g_rd_reg
      logic [7:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_comb;
      end
      assign reg_rdata = DATA_W'(rd_q);
   end else begin : g_rd_comb
      assign reg_rdata = DATA_W'(rd_comb);
   end
endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       tick_1hz,
   input logic       time_wr,
   input logic       wr_sec_prot,
   input logic       alm_acc,
   input logic       irqf,
   input logic       irq,
   input logic [7:0] ctl_q,
   input logic [6:0] sec,
   input logic [2:0] dow
);
   a_r2_sec_bcd_range: assert property (@(posedge clk) disable iff (!rst_n)
      (sec[6:4] <= 3'd5) && (sec[3:0] <= 4'd9));

   a_r6_dow_range: assert property (@(posedge clk) disable iff (!rst_n)
      (dow >= 3'd1) && (dow <= 3'd7));

   a_r8_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_acc && !tick_1hz) |=> !irqf);

   a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ctl_q[0] && irqf));

   a_r10_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[7] && !time_wr) |=> $stable(sec));

   a_r11_protect_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sec_prot && !tick_1hz) |=> $stable(sec));
endmodule

bind bcd_alarm_clock cal_clock_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_1hz    (tick_1hz),
   .time_wr     (time_wr),
   .wr_sec_prot (reg_cs && reg_we && ctl_q[6] && in_map && a4 == 4'd0),
   .alm_acc     (alm_acc),
   .irqf        (irqf),
   .irq         (irq),
   .ctl_q       (ctl_q),
   .sec         (t_cur.sec),
   .dow         (t_cur.dow)
);

// File: tb/tb_bcd_alarm_clock.sv
module tb_bcd_alarm_clock;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic       reg_cs = 1'b0;
   logic       reg_we = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq;
   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bcd_alarm_clock dut (.*);

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); reg_cs = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_cs = 0; reg_we = 0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk); reg_cs = 1; reg_we = 0; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk); reg_cs = 0;
   endtask

   task automatic tick();
      @(negedge clk); tick_1hz = 1;
      @(negedge clk); tick_1hz = 0;
   endtask

   task automatic set_time(input logic [7:0] h, m, s, w, dt, mo, y);
      wr(4'd2, h); wr(4'd1, m); wr(4'd0, s);
      wr(4'd3, w); wr(4'd4, dt); wr(4'd5, mo); wr(4'd6, y);
   endtask

   task automatic expect_reg(input string req, input logic [3:0] a, input logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      chk(req, $sformatf("reg %0d", a), v, exp);
   endtask

   task automatic t_reset();
      expect_reg("R1", 4'd0, 8'h00); expect_reg("R1", 4'd2, 8'h00);
      expect_reg("R1", 4'd3, 8'h01); expect_reg("R1", 4'd4, 8'h01);
      expect_reg("R1", 4'd5, 8'h01); expect_reg("R1", 4'd6, 8'h00);
      expect_reg("R1", 4'd9, 8'h00); expect_reg("R1", 4'd11, 8'h00);
      expect_reg("R1", 4'd12, 8'h00);
   endtask

   task automatic t_sec_min();
      set_time(8'h12, 8'h59, 8'h59, 8'h01, 8'h01, 8'h01, 8'h00);
      tick();
      expect_reg("R2", 4'd0, 8'h00); expect_reg("R2", 4'd1, 8'h00);
      expect_reg("R3", 4'd2, 8'h13);
      wr(4'd0, 8'h09); tick();
      expect_reg("R2", 4'd0, 8'h10);
   endtask

   task automatic t_day24();
      set_time(8'h23, 8'h59, 8'h59, 8'h07, 8'h31, 8'h12, 8'h99);
      tick();
      expect_reg("R3", 4'd2, 8'h00); expect_reg("R6", 4'd3, 8'h01);
      expect_reg("R5", 4'd4, 8'h01); expect_reg("R5", 4'd5, 8'h01);
      expect_reg("R5", 4'd6, 8'h00);
   endtask

   task automatic t_12h();
      set_time(8'h71, 8'h59, 8'h59, 8'h03, 8'h15, 8'h06, 8'h24);
      tick();
      expect_reg("R4", 4'd2, 8'h52); expect_reg("R4", 4'd3, 8'h04);
      expect_reg("R4", 4'd4, 8'h16);
      wr(4'd2, 8'h51); wr(4'd1, 8'h59); wr(4'd0, 8'h59); tick();
      expect_reg("R4", 4'd2, 8'h72); expect_reg("R4", 4'd3, 8'h04);
      wr(4'd2, 8'h52); wr(4'd1, 8'h59); wr(4'd0, 8'h59); tick();
      expect_reg("R4", 4'd2, 8'h41);
      wr(4'd2, 8'h72); wr(4'd1, 8'h59); wr(4'd0, 8'h59); tick();
      expect_reg("R4", 4'd2, 8'h61);
   endtask

   task automatic day_end(input logic [7:0] dt, mo, y, input logic [7:0] exp_dt, exp_mo);
      set_time(8'h23, 8'h59, 8'h59, 8'h01, dt, mo, y);
      tick();
      expect_reg("R5", 4'd4, exp_dt); expect_reg("R5", 4'd5, exp_mo);
   endtask

   task automatic t_leap();
      day_end(8'h28, 8'h02, 8'h24, 8'h29, 8'h02);
      day_end(8'h29, 8'h02, 8'h24, 8'h01, 8'h03);
      day_end(8'h28, 8'h02, 8'h23, 8'h01, 8'h03);
      day_end(8'h28, 8'h02, 8'h00, 8'h29, 8'h02);
      day_end(8'h28, 8'h02, 8'h10, 8'h01, 8'h03);
      day_end(8'h30, 8'h04, 8'h10, 8'h01, 8'h05);
      day_end(8'h30, 8'h01, 8'h10, 8'h31, 8'h01);
   endtask

   task automatic t_alarm();
      logic [7:0] v;
      wr(4'd11, 8'h00);
      set_time(8'h08, 8'h00, 8'h04, 8'h02, 8'h01, 8'h01, 8'h00);
      wr(4'd7, 8'h05); wr(4'd8, 8'h00); wr(4'd9, 8'h08); wr(4'd10, 8'h02);
      tick();
      expect_reg("R7", 4'd12, 8'h01);
      #1 chk("R9", "irq disabled", {7'b0, irq}, 8'h00);
      wr(4'd11, 8'h01);
      #1 chk("R9", "irq enabled", {7'b0, irq}, 8'h01);
      rd(4'd7, v);
      chk("R8", "alarm sec readback", v, 8'h05);
      expect_reg("R8", 4'd12, 8'h00);
      #1 chk("R9", "irq after clear", {7'b0, irq}, 8'h00);
      // weekly alarm, wrong day: no match
      wr(4'd10, 8'h03); wr(4'd0, 8'h04); tick();
      expect_reg("R7", 4'd12, 8'h00);
      // daily: day lane masked
      wr(4'd10, 8'h83); wr(4'd0, 8'h04); tick();
      expect_reg("R7", 4'd12, 8'h01);
      wr(4'd10, 8'h83);
      expect_reg("R8", 4'd12, 8'h00);
      // hourly: day and hour masked, different hour
      wr(4'd9, 8'h88); wr(4'd2, 8'h15); wr(4'd0, 8'h04); tick();
      expect_reg("R7", 4'd12, 8'h01);
      rd(4'd9, v);
      // every minute: second lane still compared
      wr(4'd8, 8'h80); wr(4'd7, 8'h30); wr(4'd0, 8'h10); tick();
      expect_reg("R7", 4'd12, 8'h00);
      // every second
      wr(4'd7, 8'h80); tick();
      expect_reg("R7", 4'd12, 8'h01);
      wr(4'd7, 8'h80);
      wr(4'd11, 8'h00);
   endtask

   task automatic t_stop();
      wr(4'd11, 8'h80); wr(4'd0, 8'h40); tick();
      expect_reg("R10", 4'd0, 8'h40);
      wr(4'd11, 8'h00); tick();
      expect_reg("R10", 4'd0, 8'h41);
   endtask

   task automatic t_protect();
      wr(4'd11, 8'h40); wr(4'd0, 8'h33);
      expect_reg("R11", 4'd0, 8'h41);
      wr(4'd9, 8'h12);
      expect_reg("R11", 4'd9, 8'h88);
      wr(4'd11, 8'h00); wr(4'd0, 8'h33);
      expect_reg("R11", 4'd0, 8'h33);
   endtask

   task automatic t_unused();
      wr(4'd3, 8'hF5); expect_reg("R12", 4'd3, 8'h05);
      wr(4'd2, 8'h92); expect_reg("R12", 4'd2, 8'h12);
      wr(4'd10, 8'hFF); expect_reg("R12", 4'd10, 8'h87);
      wr(4'd13, 8'hAA); expect_reg("R12", 4'd13, 8'h00);
      wr(4'd11, 8'h3E); expect_reg("R12", 4'd11, 8'h00);
   endtask

   task automatic t_collide();
      wr(4'd0, 8'h20);
      @(negedge clk); reg_cs = 1; reg_we = 1; reg_addr = 4'd1; reg_wdata = 8'h05; tick_1hz = 1;
      @(negedge clk); reg_cs = 0; reg_we = 0; tick_1hz = 0;
      expect_reg("R13", 4'd0, 8'h20); expect_reg("R13", 4'd1, 8'h05);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_sec_min();
      t_day24();
      t_12h();
      t_leap();
      t_alarm();
      t_stop();
      t_protect();
      t_unused();
      t_collide();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule